// File: doc/BRIEF.md
# Serial Flash Command Guard

This block is the command front end of a serial flash slave device. It watches an SPI mode 0 link: bytes arrive most significant bit first, are sampled on the rising edge of the serial clock, and are framed by an active-low select line. All three link inputs are resynchronised into the system clock domain. The block decodes the first byte of each frame as an opcode and holds the write-enable latch, the protect level, the status lock bit and the power state. It decides whether each status-write, program or erase frame is allowed to proceed.

When a frame is allowed, the block sends a one-cycle start pulse to an external memory-array model. The pulse carries the operation kind and the target address. The model reports back through a busy level and a one-cycle done pulse. Protection has several layers, and any one of them is enough to drop a frame:
- a frame length that is not a whole number of bytes;
- a clear write-enable latch;
- a target inside the read-only top region of the array;
- the hardware write-protect pin together with the lock bit;
- deep power-down;
- an operation still in progress.

The frame parser is one state machine. Its states are:
- ST_IDLE: no frame.
- ST_OPCODE: the first byte is being received.
- ST_ADDR: the address bytes are being received.
- ST_PAYLOAD: data bytes for a status write or a page program.
- ST_STATUS_OUT: the status byte is being streamed out.
- ST_DISCARD: the rest of the frame is counted but not used.

Its transitions are:
- ST_IDLE goes to ST_OPCODE when the select line falls.
- ST_OPCODE goes on when the first byte completes: to ST_PAYLOAD for a status write, to ST_ADDR for a program or sector erase, to ST_STATUS_OUT for a status read outside deep power-down, and to ST_DISCARD for everything else.
- ST_ADDR, after the last address byte, goes to ST_PAYLOAD for a program and to ST_DISCARD for a sector erase.
- Every state returns to ST_IDLE when the select line rises. The accept decision is taken at that moment.

Top module: `flash_cmd_guard`

## Requirements
- R1: Opcodes are 06h write enable, 04h write disable, 05h status read, 01h status write, 02h page program, D8h sector erase, C7h bulk erase, B9h deep power-down and ABh wake. A frame whose first byte is incomplete has no effect.
- R2: The write-enable latch is status bit 1. Write enable sets it and write disable clears it. A status write, program or erase is rejected while the latch is 0, and a rejected frame leaves the latch unchanged.
- R3: A status write, program or erase is accepted only when the count of rising clock edges in the frame is a multiple of eight. It also needs a minimum length: status write 2 bytes, sector erase 4 bytes, page program 5 bytes, bulk erase 1 byte.
- R4: The write-enable latch returns to 0 when the done pulse of an accepted operation arrives.
- R5: Status bit 0 reads 1 from the accepted frame until the done pulse, and also whenever the busy input is 1. While it is 1, every frame except a status read is ignored.
- R6: The power output reads 01 (active) while select is low or bit 0 is 1. It reads 00 (standby) otherwise, outside deep power-down.
- R7: B9h sets the power output to 10 (deep power-down). In that state every frame other than ABh is ignored, and the write-enable latch is kept. ABh returns the power output to 00.
- R8: The protect level is status bits 4:2 and the sector is address bits 23:18. A nonzero level L makes the top 2^(L-1) of the 64 sectors read-only, and level 7 covers all of them. Programs and sector erases into that region are rejected. A bulk erase is rejected whenever the level is nonzero.
- R9: An accepted status write copies data bit 7 to the lock bit (status bit 7) and data bits 4:2 to the protect level. It is rejected when wp_n is 0 and the lock bit is 1.
- R10: After opcode 05h, miso shifts out the status byte MSB first, advancing after each rising clock edge and reloading the live status every 8 bits.
- R11: An accepted frame raises op_start for one cycle. op_kind is 00 for a status write, 01 for a page program, 10 for a sector erase and 11 for a bulk erase, and op_addr holds the 24-bit address.
- R12: After reset the status byte is 00h, the power output is 00, and op_start and miso are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI select, active low |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial status data out of the block |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| arr_busy | input | 1 | Array model is executing an operation |
| arr_done | input | 1 | One-cycle pulse at the end of the operation |
| op_start | output | 1 | One-cycle start request to the array model |
| op_kind | output | 2 | Operation kind for the request |
| op_addr | output | 24 | Target address for the request |
| stat_o | output | 8 | Live status byte |
| pwr_o | output | 2 | Power state: 00 standby, 01 active, 10 deep |

## Verification
The bench builds the block with its default parameters: three address bytes, 64 sectors and two synchroniser stages. With 64 sectors, the boundary sectors 62 and 63 are reachable with one-level protection, and level 7 can cover sector 0. With three address bytes, the minimum-length and partial-byte frames fall on 17-bit and 33-bit lengths. The busy time of the array model is stretched in one test, so that write-disable and status-read frames land inside an operation.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_PAYLOAD,
        ST_STATUS_OUT,
        ST_DISCARD
    } frame_state_t;

    typedef enum logic [1:0] {
        PWR_STANDBY = 2'b00,
        PWR_ACTIVE  = 2'b01,
        PWR_DEEP    = 2'b10
    } pwr_state_t;

    typedef enum logic [1:0] {
        OPK_STATUS  = 2'b00,
        OPK_PROGRAM = 2'b01,
        OPK_SECTOR  = 2'b10,
        OPK_BULK    = 2'b11
    } op_kind_t;

    localparam logic [7:0] OPC_WR_EN      = 8'h06;
    localparam logic [7:0] OPC_WR_DIS     = 8'h04;
    localparam logic [7:0] OPC_STAT_RD    = 8'h05;
    localparam logic [7:0] OPC_STAT_WR    = 8'h01;
    localparam logic [7:0] OPC_PROG       = 8'h02;
    localparam logic [7:0] OPC_SECT_ERASE = 8'hD8;
    localparam logic [7:0] OPC_BULK_ERASE = 8'hC7;
    localparam logic [7:0] OPC_SLEEP      = 8'hB9;
    localparam logic [7:0] OPC_WAKE       = 8'hAB;

endpackage

// File: rtl/flash_spi_rx.sv
`timescale 1ns/1ps
// Resynchronises the SPI pins and assembles mode 0 bytes, MSB first.
module flash_spi_rx #(
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    output logic       sel,
    output logic       frame_start,
    output logic       frame_end,
    output logic       bit_rise,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       aligned
);
    logic [SYNC_LEN-1:0] cs_s, ck_s, d_s;
    logic                cs_q, ck_q;
    logic [2:0]          bit_cnt;

    assign sel         = !cs_s[SYNC_LEN-1];
    assign frame_start = cs_q && !cs_s[SYNC_LEN-1];
    assign frame_end   = !cs_q && cs_s[SYNC_LEN-1];
    assign bit_rise    = sel && ck_s[SYNC_LEN-1] && !ck_q;
    assign aligned     = (bit_cnt == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s       <= '1;
            ck_s       <= '0;
            d_s        <= '0;
            cs_q       <= 1'b1;
            ck_q       <= 1'b0;
            bit_cnt    <= 3'd0;
            rx_byte    <= 8'h00;
            byte_valid <= 1'b0;
        end else begin
            cs_s       <= {cs_s[SYNC_LEN-2:0], cs_n};
            ck_s       <= {ck_s[SYNC_LEN-2:0], sclk};
            d_s        <= {d_s[SYNC_LEN-2:0], mosi};
            cs_q       <= cs_s[SYNC_LEN-1];
            ck_q       <= ck_s[SYNC_LEN-1];
            byte_valid <= bit_rise && (bit_cnt == 3'd7);
            if (frame_start) begin
                bit_cnt <= 3'd0;
            end else if (bit_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_byte <= {rx_byte[6:0], d_s[SYNC_LEN-1]};
            end
        end
    end
endmodule

// File: rtl/flash_prot_map.sv
`timescale 1ns/1ps
// Decides whether a sector lies in the read-only top region.
module flash_prot_map #(
    parameter int SECT_W = 6
) (
    input  logic [2:0]        level,
    input  logic [SECT_W-1:0] sector,
    output logic              locked
);
    localparam logic [SECT_W:0] FULL = {1'b1, {SECT_W{1'b0}}};
    localparam logic [SECT_W:0] ONE  = {{SECT_W{1'b0}}, 1'b1};

    logic [SECT_W:0] span;
    logic [SECT_W:0] reach;

    always_comb begin
        if (level == 3'd0)
            span = '0;
        else if (32'(level) > SECT_W)
            span = FULL;
        else
            span = ONE << (level - 3'd1);
        reach  = {1'b0, sector} + span;
        locked = reach[SECT_W];
    end
endmodule

// File: rtl/flash_cmd_guard.sv
`timescale 1ns/1ps
module flash_cmd_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int SECT_W     = 6,
    parameter int SYNC_LEN   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    mosi,
    output logic                    miso,
    input  logic                    wp_n,
    input  logic                    arr_busy,
    input  logic                    arr_done,
    output logic                    op_start,
    output logic [1:0]              op_kind,
    output logic [8*ADDR_BYTES-1:0] op_addr,
    output logic [7:0]              stat_o,
    output logic [1:0]              pwr_o
);
    localparam int ADDR_W  = 8 * ADDR_BYTES;
    localparam int CNT_MAX = ADDR_BYTES + 2;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    frame_state_t     state_q, state_d;
    logic             sel, frame_start, frame_end, bit_rise, byte_valid, aligned;
    logic [7:0]       rx_byte, opc_q, miso_sr, stat_byte;
    logic [ADDR_W-1:0] addr_q;
    logic [3:0]       data_q;
    logic [CNT_W-1:0] nbytes_q;
    logic             wel_q, lock_q, deep_q, inflight_q, wip;
    logic [2:0]       lvl_q;
    logic             region_locked, hw_locked, go, accept;
    op_kind_t         kind;

    flash_spi_rx #(.SYNC_LEN(SYNC_LEN)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .sel(sel), .frame_start(frame_start), .frame_end(frame_end),
        .bit_rise(bit_rise), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .aligned(aligned)
    );

    flash_prot_map #(.SECT_W(SECT_W)) u_prot (
        .level(lvl_q), .sector(addr_q[ADDR_W-1 -: SECT_W]), .locked(region_locked)
    );

    assign wip       = inflight_q | arr_busy;
    assign stat_byte = {lock_q, 2'b00, lvl_q, wel_q, wip};
    assign stat_o    = stat_byte;
    assign hw_locked = !wp_n && lock_q;
    assign miso      = (state_q == ST_STATUS_OUT) ? miso_sr[7] : 1'b0;

    always_comb begin
        if (deep_q)           pwr_o = PWR_DEEP;
        else if (sel || wip)  pwr_o = PWR_ACTIVE;
        else                  pwr_o = PWR_STANDBY;
    end

    // Accept decision for modifying frames, evaluated at select rise
    always_comb begin
        go     = frame_end && !deep_q && !wip && aligned && wel_q;
        accept = 1'b0;
        kind   = OPK_STATUS;
        case (opc_q)
            OPC_STAT_WR: begin
                accept = go && (nbytes_q >= CNT_W'(2)) && !hw_locked;
                kind   = OPK_STATUS;
            end
            OPC_PROG: begin
                accept = go && (nbytes_q >= CNT_W'(ADDR_BYTES + 2)) && !region_locked;
                kind   = OPK_PROGRAM;
            end
            OPC_SECT_ERASE: begin
                accept = go && (nbytes_q >= CNT_W'(ADDR_BYTES + 1)) && !region_locked;
                kind   = OPK_SECTOR;
            end
            OPC_BULK_ERASE: begin
                accept = go && (lvl_q == 3'd0);
                kind   = OPK_BULK;
            end
            default: ;
        endcase
    end

    // Frame parser next state
    always_comb begin
        state_d = state_q;
        if (frame_end) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:
                    if (frame_start) state_d = ST_OPCODE;
                ST_OPCODE:
                    if (byte_valid) begin
                        if (rx_byte == OPC_STAT_WR)
                            state_d = ST_PAYLOAD;
                        else if (rx_byte == OPC_PROG || rx_byte == OPC_SECT_ERASE)
                            state_d = ST_ADDR;
                        else if (rx_byte == OPC_STAT_RD && !deep_q)
                            state_d = ST_STATUS_OUT;
                        else
                            state_d = ST_DISCARD;
                    end
                ST_ADDR:
                    if (byte_valid && nbytes_q == CNT_W'(ADDR_BYTES))
                        state_d = (opc_q == OPC_PROG) ? ST_PAYLOAD : ST_DISCARD;
                ST_PAYLOAD, ST_STATUS_OUT, ST_DISCARD: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q      <= 8'h00;
            addr_q     <= '0;
            data_q     <= 4'h0;
            nbytes_q   <= '0;
            miso_sr    <= 8'h00;
            wel_q      <= 1'b0;
            lock_q     <= 1'b0;
            lvl_q      <= 3'd0;
            deep_q     <= 1'b0;
            inflight_q <= 1'b0;
            op_start   <= 1'b0;
            op_kind    <= 2'b00;
            op_addr    <= '0;
        end else begin
            op_start <= 1'b0;
            if (frame_start) begin
                nbytes_q <= '0;
                opc_q    <= 8'h00;
            end else if (byte_valid) begin
                if (nbytes_q != CNT_W'(CNT_MAX)) nbytes_q <= nbytes_q + CNT_W'(1);
                if (state_q == ST_OPCODE) opc_q <= rx_byte;
                if (state_q == ST_ADDR)   addr_q <= ADDR_W'({addr_q, rx_byte});
                if (state_q == ST_PAYLOAD && opc_q == OPC_STAT_WR && nbytes_q == CNT_W'(1))
                    data_q <= {rx_byte[7], rx_byte[4:2]};
            end
            if (state_q == ST_OPCODE && state_d == ST_STATUS_OUT) begin
                miso_sr <= stat_byte;
            end else if (state_q == ST_STATUS_OUT) begin
                if (byte_valid)    miso_sr <= stat_byte;
                else if (bit_rise) miso_sr <= {miso_sr[6:0], 1'b0};
            end
            if (arr_done && inflight_q) begin
                inflight_q <= 1'b0;
                wel_q      <= 1'b0;
            end
            if (frame_end && !wip) begin
                if (deep_q) begin
                    if (opc_q == OPC_WAKE) deep_q <= 1'b0;
                end else begin
                    if (opc_q == OPC_WR_EN)  wel_q  <= 1'b1;
                    if (opc_q == OPC_WR_DIS) wel_q  <= 1'b0;
                    if (opc_q == OPC_SLEEP)  deep_q <= 1'b1;
                    if (accept) begin
                        op_start   <= 1'b1;
                        op_kind    <= kind;
                        op_addr    <= addr_q;
                        inflight_q <= 1'b1;
                        if (opc_q == OPC_STAT_WR) begin
                            lock_q <= data_q[3];
                            lvl_q  <= data_q[2:0];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/flash_cmd_guard_chk.sv
`timescale 1ns/1ps
module flash_cmd_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_start,
    input logic       arr_done,
    input logic       busy_bit,
    input logic       wel_bit,
    input logic [1:0] pwr_o
);
    assert_start_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wel_bit));

    assert_done_clears_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_done && busy_bit) |=> !wel_bit);

    assert_start_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !$past(busy_bit));

    assert_busy_not_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_bit |-> (pwr_o != 2'b00));

    assert_no_start_in_deep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($past(pwr_o) != 2'b10));

    assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);
endmodule

bind flash_cmd_guard flash_cmd_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .arr_done(arr_done),
    .busy_bit(stat_o[0]), .wel_bit(stat_o[1]), .pwr_o(pwr_o)
);

// File: tb/flash_cmd_guard_test.sv
`timescale 1ns/1ps
module flash_cmd_guard_test;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic arr_busy, arr_done, miso, op_start;
    logic [1:0]  op_kind, pwr_o;
    logic [23:0] op_addr;
    logic [7:0]  stat_o;

    int errors = 0, checks = 0, n_start = 0, busy_cnt = 0, busy_len = 20;
    logic [1:0]  last_kind;
    logic [23:0] last_addr;
    logic [31:0] rd_bits = '0;

    always #4 clk = ~clk;

    flash_cmd_guard uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .wp_n(wp_n), .arr_busy(arr_busy), .arr_done(arr_done),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .stat_o(stat_o), .pwr_o(pwr_o)
    );

    // Array model: busy for busy_len cycles after each start, then done
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_busy <= 1'b0; arr_done <= 1'b0; busy_cnt <= 0;
            last_kind <= 2'b00; last_addr <= '0;
        end else begin
            arr_done <= 1'b0;
            if (op_start) begin
                n_start   <= n_start + 1;
                last_kind <= op_kind;
                last_addr <= op_addr;
                arr_busy  <= 1'b1;
                busy_cnt  <= busy_len;
            end else if (arr_busy) begin
                if (busy_cnt == 0) begin
                    arr_busy <= 1'b0;
                    arr_done <= 1'b1;
                end else begin
                    busy_cnt <= busy_cnt - 1;
                end
            end
        end
    end

    typedef struct packed {
        logic [39:0] frame;
        logic [7:0]  nbits;
        logic        wp;
        logic        start;
        logic [1:0]  kind;
        logic [23:0] addr;
        logic [7:0]  stat;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h02}, // R2 set latch
        '{40'h0400000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h00}, // R2 clear latch
        '{40'h0200010055, 8'd40, 1'b1, 1'b0, 2'd0, 24'h000000, 8'h00}, // R2 no latch
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h02},
        '{40'hD810000000, 8'd33, 1'b1, 1'b0, 2'd0, 24'h000000, 8'h02}, // R3 odd length
        '{40'hD810000000, 8'd32, 1'b1, 1'b1, 2'd2, 24'h100000, 8'h00}, // R4 latch cleared
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h02},
        '{40'h011C000000, 8'd16, 1'b1, 1'b1, 2'd0, 24'h000000, 8'h1C}, // R9 level 7
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h1E},
        '{40'hD800000000, 8'd32, 1'b1, 1'b0, 2'd0, 24'h000000, 8'h1E}, // R8 all locked
        '{40'h0184000000, 8'd16, 1'b1, 1'b1, 2'd0, 24'h000000, 8'h84}, // R9 level 1 + lock
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h86},
        '{40'hD8FC000000, 8'd32, 1'b1, 1'b0, 2'd0, 24'h000000, 8'h86}, // R8 sector 63
        '{40'hD8F8000000, 8'd32, 1'b1, 1'b1, 2'd2, 24'hF80000, 8'h84}, // R8 sector 62
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h86},
        '{40'hC700000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h86}, // R8 bulk blocked
        '{40'h0100000000, 8'd16, 1'b0, 1'b0, 2'd0, 24'h000000, 8'h86}, // R9 pin lock
        '{40'h0100000000, 8'd16, 1'b1, 1'b1, 2'd0, 24'h000000, 8'h00}, // R9 pin free
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h02},
        '{40'hC700000000, 8'd8,  1'b1, 1'b1, 2'd3, 24'h000000, 8'h00}, // R11 bulk kind
        '{40'h0600000000, 8'd8,  1'b1, 1'b0, 2'd0, 24'h000000, 8'h02},
        '{40'h0100000000, 8'd17, 1'b1, 1'b0, 2'd0, 24'h000000, 8'h02}, // R3 17 bits
        '{40'h0200010055, 8'd40, 1'b1, 1'b1, 2'd1, 24'h000100, 8'h00}  // R11 program
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [39:0] fr, input int nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = fr[39-i];
            repeat (HALF) @(negedge clk);
            rd_bits = {rd_bits[30:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (arr_busy || arr_done) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 status", 32'(stat_o), 32'h00);
        check("R12 power", 32'(pwr_o), 32'h0);
        check("R12 op_start", 32'(op_start), 32'h0);
        check("R12 miso", 32'(miso), 32'h0);

        for (int v = 0; v < NV; v++) begin
            wp_n = VEC[v].wp;
            s0 = n_start;
            xfer(VEC[v].frame, int'(VEC[v].nbits));
            check("R3 accept outcome", 32'(n_start - s0), 32'(VEC[v].start));
            wait_idle();
            if (VEC[v].start) begin
                check("R11 op kind", 32'(last_kind), 32'(VEC[v].kind));
                if (VEC[v].kind == 2'd1 || VEC[v].kind == 2'd2)
                    check("R11 op addr", 32'(last_addr), 32'(VEC[v].addr));
            end
            check("R2 status after frame", 32'(stat_o), 32'(VEC[v].stat));
            wp_n = 1'b1;
        end

        // R1: incomplete opcode does nothing
        xfer(40'h0600000000, 4);
        check("R1 partial opcode", 32'(stat_o), 32'h00);

        // R6: select low alone means active
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 active while selected", 32'(pwr_o), 32'h1);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R6 standby when idle", 32'(pwr_o), 32'h0);

        // R10: status read streams the byte twice
        xfer(40'h0600000000, 8);
        xfer(40'h0500000000, 24);
        check("R10 status stream", rd_bits & 32'hFFFF, 32'h0202);

        // R5: busy window
        busy_len = 800;
        s0 = n_start;
        xfer(40'h0200010055, 40);
        check("R5 busy bit", 32'(stat_o), 32'h03);
        check("R6 active while busy", 32'(pwr_o), 32'h1);
        xfer(40'h0400000000, 8);
        check("R5 disable ignored while busy", 32'(stat_o), 32'h03);
        xfer(40'h0500000000, 16);
        check("R5 status read while busy", rd_bits & 32'hFF, 32'h03);
        check("R5 single start", 32'(n_start - s0), 32'h1);
        wait_idle();
        busy_len = 20;
        check("R4 latch after done", 32'(stat_o), 32'h00);
        check("R6 standby after done", 32'(pwr_o), 32'h0);

        // R7: deep power-down
        xfer(40'h0600000000, 8);
        xfer(40'hB900000000, 8);
        check("R7 deep entered", 32'(pwr_o), 32'h2);
        xfer(40'h0400000000, 8);
        check("R7 disable ignored", 32'(stat_o), 32'h02);
        s0 = n_start;
        xfer(40'hD800000000, 32);
        check("R7 erase ignored", 32'(n_start - s0), 32'h0);
        rd_bits = '1;
        xfer(40'h0500000000, 16);
        check("R7 status read ignored", rd_bits & 32'hFF, 32'h00);
        xfer(40'hAB00000000, 8);
        check("R7 wake", 32'(pwr_o), 32'h0);
        s0 = n_start;
        xfer(40'hD800000000, 32);
        check("R7 latch kept through deep", 32'(n_start - s0), 32'h1);
        wait_idle();
        check("R4 latch cleared", 32'(stat_o), 32'h00);

        finish_run();
    end
endmodule